// File: doc/BRIEF.md
# System Clock Control Register

An 8-bit control register that sets how the system clock tree behaves. It chooses the clock source, stops the main oscillator, enables the sub oscillator, sets the drive strength and the divide-by-8 mode, and chooses what appears on a clock-output pin. Software writes it over a simple single-cycle write strobe. A write counts only when a separate protect-enable input is high. Otherwise the register keeps its value.

Hardware state can override the stored value:

- Stop-mode entry forces some bits.
- Both oscillators being off forces some bits.
- The sub oscillator being disabled forces some bits.

When an override and a software write land in the same cycle, the override wins. Readback always shows the effective value, forced bits included.

A request to switch the system clock to the sub clock is refused unless the sub oscillator reports that it is stable. The refusal raises a one-cycle flag.

The clock-output pin chooses between a port level and three prescaled clocks. It changes selection only while both the old and the new divided clocks are low, so the pin never glitches.

Top module: `sysclk_ctrl_reg`

## Requirements
- R1: After a synchronous reset, readback is 8'h48, which means divide-by-8 on, high drive, main oscillator running, main source selected and port mode on the pin. The clock-output pin then carries the port level.
- R2: A write strobe while protect-enable is 0 leaves the register unchanged. While protect-enable is 1, the written byte is stored, subject to R4, R5, R6, R8 and R9.
- R3: The field outputs follow the stored bits as follows:
  - periph_stop_wait is bit 2.
  - drive_high is bit 3.
  - sub_osc_en is bit 4.
  - main_osc_stop is bit 5.
  - div8_mode is bit 6.
  - sys_src_sub is bit 7.
- R4: While bit 4 (sub oscillator enable) is 0, bit 3 (drive strength) reads 1.
- R5: A cycle with stop_entry high sets bits 6 and 3 to 1.
- R6: While onchip_on is 0 and bit 5 is 1, bit 6 is forced to 1 and cannot be cleared by a write. In that state main_drive_lock reads 1.
- R7: Bits [1:0] choose the pin source:
  - 00 gives port_level.
  - 01 gives clk_fc.
  - 10 gives clk_f8.
  - 11 gives clk_f32.
- R8: A write that would take bit 7 from 0 to 1 while sub_stable is 0 leaves bit 7 at 0. It pulses sel_reject for one cycle. Clearing bit 7 is always accepted.
- R9: When a forcing condition and an accepted write fall in the same cycle, the forced bits take their forced value.
- R10: The pin source changes only in a cycle where both the current source and the requested source are low. Port mode counts as low. Until then, the pin keeps following the old source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| prot_en | input | 1 | Protect-enable; writes count only when 1 |
| onchip_on | input | 1 | On-chip oscillator running flag |
| stop_entry | input | 1 | Stop-mode entry pulse |
| sub_stable | input | 1 | Sub oscillator stable flag |
| port_level | input | 1 | Level driven on the pin in port mode |
| clk_fc | input | 1 | Low-speed divided clock |
| clk_f8 | input | 1 | Divide-by-8 clock |
| clk_f32 | input | 1 | Divide-by-32 clock |
| rd_data | output | 8 | Effective register value |
| periph_stop_wait | output | 1 | Peripheral clock stops in wait mode |
| drive_high | output | 1 | High drive strength for the sub oscillator |
| sub_osc_en | output | 1 | Sub oscillator pins in oscillator mode |
| main_osc_stop | output | 1 | Main oscillator stopped |
| div8_mode | output | 1 | Divide-by-8 mode |
| sys_src_sub | output | 1 | Sub clock selected as system clock |
| main_drive_lock | output | 1 | Companion high-drive hold while both oscillators are off |
| sel_reject | output | 1 | One-cycle flag for a refused sub-clock switch |
| clk_out | output | 1 | Clock-output pin |

## Verification
The bench builds the block with its default parameters: an 8-bit register, reset value 8'h48, and four pin sources. This setting makes every force rule and every pin encoding reachable.

The prescaled clocks are slow levels driven by the bench, not free-running clocks. This lets the bench hold the old or the new source high and show that the swap waits. It also lets a write collide with stop entry, or with the oscillator-off state, in a chosen cycle.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] REG_RESET = 8'h48;
  localparam int B_PSTOP = 2;
  localparam int B_DRIVE = 3;
  localparam int B_SUBEN = 4;
  localparam int B_MSTOP = 5;
  localparam int B_DIV8 = 6;
  localparam int B_SRC = 7;
  localparam int N_SRC = 4;
  localparam int SEL_W = $clog2(N_SRC);
endpackage

// File: rtl/sysclk_force.sv
module sysclk_force
  import sysclk_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic [W-1:0] cur,
  input  logic         wr_fire,
  input  logic [W-1:0] wr_data,
  input  logic         onchip_on,
  input  logic         stop_entry,
  input  logic         sub_stable,
  output logic [W-1:0] nxt,
  output logic         reject,
  output logic         lock
);
  always_comb begin
    nxt = cur;
    reject = 1'b0;
    if (wr_fire) begin
      nxt = wr_data;
      if (wr_data[B_SRC] && !cur[B_SRC] && !sub_stable) begin
        nxt[B_SRC] = 1'b0;
        reject = 1'b1;
      end
    end
    if (stop_entry) begin
      nxt[B_DIV8] = 1'b1;
      nxt[B_DRIVE] = 1'b1;
    end
    if (!nxt[B_SUBEN]) nxt[B_DRIVE] = 1'b1;
    lock = !onchip_on && nxt[B_MSTOP];
    if (lock) nxt[B_DIV8] = 1'b1;
  end
endmodule

// File: rtl/sysclk_outmux.sv
module sysclk_outmux
  import sysclk_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] req_sel,
  input  logic          port_level,
  input  logic [NS-1:0] src_in,
  output logic          clk_out
);
  logic [NS-1:0] lvl;
  logic [NS-1:0] outv;
  logic [SW-1:0] sel_q;
  logic [SW-1:0] sel_nxt;

  genvar gi;
  generate
    for (gi = 0; gi < NS; gi++) begin : g_src
      if (gi == 0) begin : g_port
        assign lvl[gi] = 1'b0;
        assign outv[gi] = port_level;
      end else begin : g_div
        assign lvl[gi] = src_in[gi];
        assign outv[gi] = src_in[gi];
      end
    end
  endgenerate

  always_comb begin
    sel_nxt = sel_q;
    if (!lvl[sel_q] && !lvl[req_sel]) sel_nxt = req_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      clk_out <= 1'b0;
    end else begin
      sel_q <= sel_nxt;
      clk_out <= outv[sel_nxt];
    end
  end
endmodule

// File: rtl/sysclk_ctrl_reg.sv
module sysclk_ctrl_reg
  import sysclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             prot_en,
  input  logic             onchip_on,
  input  logic             stop_entry,
  input  logic             sub_stable,
  input  logic             port_level,
  input  logic             clk_fc,
  input  logic             clk_f8,
  input  logic             clk_f32,
  output logic [REG_W-1:0] rd_data,
  output logic             periph_stop_wait,
  output logic             drive_high,
  output logic             sub_osc_en,
  output logic             main_osc_stop,
  output logic             div8_mode,
  output logic             sys_src_sub,
  output logic             main_drive_lock,
  output logic             sel_reject,
  output logic             clk_out
);
  logic [REG_W-1:0] reg_q;
  logic [REG_W-1:0] reg_nxt;
  logic             rej_c;
  logic             lock_c;
  logic             rej_q;
  logic             lock_q;

  sysclk_force #(.W(REG_W)) u_force (
    .cur(reg_q), .wr_fire(wr_en && prot_en), .wr_data(wr_data),
    .onchip_on(onchip_on), .stop_entry(stop_entry), .sub_stable(sub_stable),
    .nxt(reg_nxt), .reject(rej_c), .lock(lock_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q <= REG_RESET;
      rej_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      reg_q <= reg_nxt;
      rej_q <= rej_c;
      lock_q <= lock_c;
    end
  end

  sysclk_outmux #(.NS(N_SRC), .SW(SEL_W)) u_mux (
    .clk(clk), .rst(rst), .req_sel(reg_q[SEL_W-1:0]),
    .port_level(port_level),
    .src_in({clk_f32, clk_f8, clk_fc, 1'b0}),
    .clk_out(clk_out)
  );

  assign rd_data = reg_q;
  assign periph_stop_wait = reg_q[B_PSTOP];
  assign drive_high = reg_q[B_DRIVE];
  assign sub_osc_en = reg_q[B_SUBEN];
  assign main_osc_stop = reg_q[B_MSTOP];
  assign div8_mode = reg_q[B_DIV8];
  assign sys_src_sub = reg_q[B_SRC];
  assign main_drive_lock = lock_q;
  assign sel_reject = rej_q;
endmodule

// File: rtl/sysclk_ctrl_chk.sv
module sysclk_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       prot_en,
  input logic       onchip_on,
  input logic       stop_entry,
  input logic       sub_stable,
  input logic [7:0] rd_data,
  input logic       sel_reject
);
  // R2
  protect_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && prot_en) |=> (rd_data[7] == $past(rd_data[7])) && (rd_data[2:0] == $past(rd_data[2:0])));
  // R4
  drive_force_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_data[4] |-> rd_data[3]);
  // R5
  stop_force_chk: assert property (@(posedge clk) disable iff (rst)
    stop_entry |=> rd_data[6] && rd_data[3]);
  // R6
  div8_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!onchip_on && rd_data[5] && !(wr_en && prot_en)) |=> rd_data[6]);
  // R8
  reject_flag_chk: assert property (@(posedge clk) disable iff (rst)
    sel_reject |-> !rd_data[7]);
  // R8
  sub_switch_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[7]) |-> $past(sub_stable));
endmodule

bind sysclk_ctrl_reg sysclk_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .prot_en(prot_en),
  .onchip_on(onchip_on), .stop_entry(stop_entry), .sub_stable(sub_stable),
  .rd_data(rd_data), .sel_reject(sel_reject)
);

// File: tb/sysclk_ctrl_reg_tb.sv
module sysclk_ctrl_reg_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, prot_en = 1'b0, onchip_on = 1'b1, stop_entry = 1'b0;
  logic sub_stable = 1'b0, port_level = 1'b0, clk_fc = 1'b0, clk_f8 = 1'b0, clk_f32 = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic periph_stop_wait, drive_high, sub_osc_en, main_osc_stop, div8_mode;
  logic sys_src_sub, main_drive_lock, sel_reject, clk_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sysclk_ctrl_reg u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .prot_en(prot_en),
    .onchip_on(onchip_on), .stop_entry(stop_entry), .sub_stable(sub_stable),
    .port_level(port_level), .clk_fc(clk_fc), .clk_f8(clk_f8), .clk_f32(clk_f32),
    .rd_data(rd_data), .periph_stop_wait(periph_stop_wait), .drive_high(drive_high),
    .sub_osc_en(sub_osc_en), .main_osc_stop(main_osc_stop), .div8_mode(div8_mode),
    .sys_src_sub(sys_src_sub), .main_drive_lock(main_drive_lock),
    .sel_reject(sel_reject), .clk_out(clk_out)
  );

  typedef struct packed {
    logic       prot;
    logic       wr;
    logic [7:0] data;
    logic       onchip;
    logic       stop;
    logic       sstab;
    logic [7:0] exp_rd;
    logic       exp_rej;
    logic       exp_lock;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TABLE [NV] = '{
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h48, 1'b0, 1'b0}, // R2 protect off
    '{1'b1, 1'b1, 8'h10, 1'b1, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0}, // R2 write
    '{1'b1, 1'b1, 8'h11, 1'b1, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0}, // R2
    '{1'b1, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h08, 1'b0, 1'b0}, // R4
    '{1'b1, 1'b1, 8'h90, 1'b1, 1'b0, 1'b0, 8'h10, 1'b1, 1'b0}, // R8 reject
    '{1'b1, 1'b1, 8'h90, 1'b1, 1'b0, 1'b1, 8'h90, 1'b0, 1'b0}, // R8 accept
    '{1'b1, 1'b1, 8'h10, 1'b1, 1'b0, 1'b0, 8'h10, 1'b0, 1'b0}, // R8 clear
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h58, 1'b0, 1'b0}, // R5
    '{1'b1, 1'b1, 8'h10, 1'b1, 1'b1, 1'b0, 8'h58, 1'b0, 1'b0}, // R9
    '{1'b1, 1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 8'h70, 1'b0, 1'b1}, // R6 R9
    '{1'b1, 1'b1, 8'h34, 1'b0, 1'b0, 1'b0, 8'h74, 1'b0, 1'b1}, // R6 no clear
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h74, 1'b0, 1'b0}, // R6 release
    '{1'b1, 1'b1, 8'h14, 1'b1, 1'b0, 1'b0, 8'h14, 1'b0, 1'b0}, // R2
    '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h14, 1'b0, 1'b0}  // R2
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic wr(input logic [7:0] d);
    prot_en = 1'b1; wr_en = 1'b1; wr_data = d;
    tick();
    wr_en = 1'b0; prot_en = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset value", rd_data, 8'h48);
    chk("R1 pin port level", {7'd0, clk_out}, 8'h00);
    chk("R1 no reject", {7'd0, sel_reject}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      prot_en = TABLE[i].prot; wr_en = TABLE[i].wr; wr_data = TABLE[i].data;
      onchip_on = TABLE[i].onchip; stop_entry = TABLE[i].stop; sub_stable = TABLE[i].sstab;
      tick();
      chk($sformatf("R2/R4/R5/R6/R8/R9 vec%0d rd", i), rd_data, TABLE[i].exp_rd);
      chk($sformatf("R8 vec%0d reject", i), {7'd0, sel_reject}, {7'd0, TABLE[i].exp_rej});
      chk($sformatf("R6 vec%0d lock", i), {7'd0, main_drive_lock}, {7'd0, TABLE[i].exp_lock});
    end
    wr_en = 1'b0; prot_en = 1'b0; stop_entry = 1'b0; onchip_on = 1'b1;

    // R3 field outputs
    sub_stable = 1'b1;
    wr(8'hB4);
    sub_stable = 1'b0;
    chk("R3 fields", {sys_src_sub, div8_mode, main_osc_stop, sub_osc_en, drive_high,
                      periph_stop_wait, 2'b00}, 8'hB4);
    // R3 and R4: after a write that clears the sub enable
    wr(8'h04);
    chk("R3 R4 fields", {sys_src_sub, div8_mode, main_osc_stop, sub_osc_en, drive_high,
                      periph_stop_wait, 2'b00}, 8'h0C);

    // R7 port mode
    port_level = 1'b1;
    wr(8'h10);
    chk("R7 port level", {7'd0, clk_out}, 8'h01);
    // R10 swap to f8 waits while f8 is high
    clk_fc = 1'b1; clk_f8 = 1'b1; port_level = 1'b0;
    wr(8'h12);
    tick();
    chk("R10 hold on port", {7'd0, clk_out}, 8'h00);
    clk_f8 = 1'b0; tick();
    clk_f8 = 1'b1; tick();
    chk("R7 f8 source", {7'd0, clk_out}, 8'h01);
    // R10 request f32 while f8 high: stays on f8
    clk_f32 = 1'b0;
    wr(8'h13);
    tick();
    chk("R10 stays on f8", {7'd0, clk_out}, 8'h01);
    clk_f8 = 1'b0; tick();
    chk("R10 swap point low", {7'd0, clk_out}, 8'h00);
    clk_f32 = 1'b1; tick();
    chk("R7 f32 source", {7'd0, clk_out}, 8'h01);
    // R7 fc source
    clk_f32 = 1'b0; clk_fc = 1'b0;
    wr(8'h11);
    tick();
    clk_fc = 1'b1; tick();
    chk("R7 fc source", {7'd0, clk_out}, 8'h01);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule